// File: doc/BRIEF.md
# Memory-Mapped BCD Real-Time Clock

This block is a byte-wide storage space of 2048 locations in which the eight highest addresses hold a clock/calendar and every lower address is ordinary read/write memory. A host reaches both through one synchronous bus made of chip select, write enable, read enable, an 11-bit address and 8-bit write and read data. The clock keeps seconds, minutes, hours (24-hour), day of week, date, month, year and century, all in packed BCD. A one-cycle pulse on the tick input advances the time by one second. Leap years are those whose two-digit year is a multiple of four, which is correct until the year 2100.

The clock is double-buffered. Running counters advance on every tick, and a separate holding copy is what the host reads and writes. Two control bits in the top of the control/century byte freeze the holding copy. The freeze bit gives a coherent snapshot while the counters keep running. The set bit allows new values to be loaded, and clearing it transfers those values into the counters. Reads are registered: data and a valid flag appear one cycle after the read strobe. There is no back-pressure; the host may issue one access per cycle.

Top module: `rtc_ram_top`

## Requirements
- R1: A write with cs and we high to an address below 0x7F8 stores the byte. A read with cs and re high returns, one cycle later, the byte last stored there on rdata with rd_valid high. rd_valid is low in every cycle that follows a cycle without a read. A read returns the contents from before any write in the same cycle.
- R2: Clock byte map: 0x7F8 control (bit 7 set-bit, bit 6 freeze-bit, bits 5:0 century BCD), 0x7F9 seconds, 0x7FA minutes, 0x7FB hours, 0x7FC day of week, 0x7FD date, 0x7FE month, 0x7FF year. Unused high bits read 0 (seconds and minutes bit 7; hours and date bits 7:6; month bits 7:5; day bits 7:3). After reset the clock reads 00:00:00, day 1, date 01, month 01, year 00, century 00, both control bits clear.
- R3: Each tick advances the seconds. Seconds 59 wraps to 00 and carries into the minutes, minutes 59 into the hours, and hours 23 wraps to 00 and carries into the calendar. Without a tick or load, the counters hold.
- R4: A day carry moves the day of week from 7 to 1 (otherwise +1). The date wraps to 01 after the last day of the month (30 for April, June, September and November; 31 for the other months except February) and carries into the month.
- R5: February ends on the 29th when the year's BCD value is a multiple of four (00 included), else on the 28th.
- R6: Month 12 wraps to 01 and carries into the year. Year 99 wraps to 00 and carries into the century, and century 39 wraps to 00.
- R7: With both control bits clear, every tick refreshes the holding copy with the post-tick counter value. A read issued in the cycle after the tick sees the new time.
- R8: While the freeze bit is set, the holding copy is not refreshed but the counters keep counting. The write that clears the freeze bit causes a refresh on the next clock edge, showing the elapsed time.
- R9: While the set bit is set, host writes to the clock bytes stay in the holding copy. The control write that clears the set bit loads the holding values into the counters, taking the century from that write's bits 5:0. Counting then continues from the loaded time.
- R10: A write to a clock byte while the set bit is clear changes only the holding copy. It is visible to a read until the next refresh replaces it with the counter value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle pulse per second |
| cs | input | 1 | Chip select for the bus access |
| we | input | 1 | Write strobe, qualified by cs |
| re | input | 1 | Read strobe, qualified by cs |
| addr | input | 11 | Byte address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid with rd_valid |
| rd_valid | output | 1 | High one cycle after an accepted read |

## Verification
A wrong counter state stays hidden until it is copied into the holding bytes. That happens on the next tick with both control bits clear, or on the first edge after the freeze bit is released. A read issued one cycle later then returns the wrong byte. An error in the holding copy or the control bits shows on the very next read of the affected byte. The reference model reads every clock byte after each rollover, load and release, so a fault is caught within two cycles of becoming observable. A RAM fault shows on the next read of that location.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  localparam int NUM_REGS = 8;
  localparam int BYTE_W   = 8;

  // Running or holding time, all fields packed BCD.
  typedef struct packed {
    logic [5:0] cent;
    logic [7:0] year;
    logic [4:0] mon;
    logic [5:0] date;
    logic [2:0] dow;
    logic [5:0] hour;
    logic [6:0] min;
    logic [6:0] sec;
  } rtc_time_t;

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    else                return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // Two-digit BCD year is a multiple of four.
  function automatic logic is_leap(input logic [7:0] y);
    if (!y[4]) return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
    else       return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
  endfunction

  function automatic logic [7:0] month_last(input logic [7:0] m, input logic [7:0] y);
    case (m)
      8'h02:                      return is_leap(y) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

  // Byte index 0 = control/century, 1..7 = seconds .. year.
  function automatic logic [7:0] field_mask(input int i);
    case (i)
      1, 2:    return 8'h7F;
      3, 5:    return 8'h3F;
      4:       return 8'h07;
      6:       return 8'h1F;
      default: return 8'hFF;
    endcase
  endfunction

  function automatic logic [7:0] reset_byte(input int i);
    case (i)
      4, 5, 6: return 8'h01;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] get_byte(input rtc_time_t t, input int i);
    case (i)
      0:       return {2'b00, t.cent};
      1:       return {1'b0, t.sec};
      2:       return {1'b0, t.min};
      3:       return {2'b00, t.hour};
      4:       return {5'b00000, t.dow};
      5:       return {2'b00, t.date};
      6:       return {3'b000, t.mon};
      default: return t.year;
    endcase
  endfunction

endpackage

// File: rtl/rtc_ram.sv
module rtc_ram #(
  parameter int ADDR_W = 11,
  parameter int DEPTH  = 2040,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic              re,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] q
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    if (re) q <= mem[addr];
  end
endmodule

// File: rtl/rtc_counters.sv
module rtc_counters
  import rtc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      tick,
  input  logic      load,
  input  rtc_time_t load_val,
  output rtc_time_t cur,
  output rtc_time_t nxt
);
  rtc_time_t adv;
  logic c_min, c_hour, c_day, c_mon, c_year, c_cent;

  always_comb begin
    adv    = cur;
    c_min  = 1'b0;
    c_hour = 1'b0;
    c_day  = 1'b0;
    c_mon  = 1'b0;
    c_year = 1'b0;
    c_cent = 1'b0;
    if (cur.sec == 7'h59) begin adv.sec = '0; c_min = 1'b1; end
    else adv.sec = 7'(bcd_inc({1'b0, cur.sec}));
    if (c_min) begin
      if (cur.min == 7'h59) begin adv.min = '0; c_hour = 1'b1; end
      else adv.min = 7'(bcd_inc({1'b0, cur.min}));
    end
    if (c_hour) begin
      if (cur.hour == 6'h23) begin adv.hour = '0; c_day = 1'b1; end
      else adv.hour = 6'(bcd_inc({2'b00, cur.hour}));
    end
    if (c_day) begin
      adv.dow = (cur.dow == 3'd7) ? 3'd1 : cur.dow + 3'd1;
      if ({2'b00, cur.date} == month_last({3'b000, cur.mon}, cur.year)) begin
        adv.date = 6'h01;
        c_mon    = 1'b1;
      end else adv.date = 6'(bcd_inc({2'b00, cur.date}));
    end
    if (c_mon) begin
      if (cur.mon == 5'h12) begin adv.mon = 5'h01; c_year = 1'b1; end
      else adv.mon = 5'(bcd_inc({3'b000, cur.mon}));
    end
    if (c_year) begin
      if (cur.year == 8'h99) begin adv.year = '0; c_cent = 1'b1; end
      else adv.year = bcd_inc(cur.year);
    end
    if (c_cent) begin
      if (cur.cent == 6'h39) adv.cent = '0;
      else adv.cent = 6'(bcd_inc({2'b00, cur.cent}));
    end
  end

  always_comb begin
    if (load)      nxt = load_val;
    else if (tick) nxt = adv;
    else           nxt = cur;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur      <= '0;
      cur.dow  <= 3'd1;
      cur.date <= 6'h01;
      cur.mon  <= 5'h01;
    end else begin
      cur <= nxt;
    end
  end

  logic end_of_day;
  assign end_of_day = (cur.sec == 7'h59) && (cur.min == 7'h59) && (cur.hour == 6'h23);

  p_sec_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load && cur.sec == 7'h59) |=> (cur.sec == 7'h00));
  p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !load) |=> $stable(cur));
  p_dow_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load && end_of_day && cur.dow == 3'd7) |=> (cur.dow == 3'd1));
  p_leap_day_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load && end_of_day && cur.mon == 5'h02 && cur.date == 6'h28 && cur.year == 8'h24)
    |=> (cur.date == 6'h29));
  p_year_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load && end_of_day && cur.mon == 5'h12 && cur.date == 6'h31 && cur.year == 8'h99)
    |=> (cur.year == 8'h00 && cur.mon == 5'h01 && cur.cent != $past(cur.cent)));
  p_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cur == $past(load_val)));
endmodule

// File: rtl/rtc_holding.sv
module rtc_holding
  import rtc_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       refresh,
  input  rtc_time_t                  refresh_val,
  input  logic                       wr_en,
  input  logic [2:0]                 wr_idx,
  input  logic [BYTE_W-1:0]          wdata,
  output logic [NUM_REGS*BYTE_W-1:0] hold_flat
);
  for (genvar i = 0; i < NUM_REGS; i++) begin : g_byte
    logic [BYTE_W-1:0] q;
    logic [BYTE_W-1:0] keep;
    // The control byte keeps its two mode bits across a refresh.
    assign keep = (i == 0) ? (q & 8'hC0) : 8'h00;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                           q <= reset_byte(i);
      else if (wr_en && wr_idx == 3'(i))    q <= wdata & field_mask(i);
      else if (refresh)                     q <= get_byte(refresh_val, i) | keep;
    end

    assign hold_flat[i*BYTE_W +: BYTE_W] = q;
  end
endmodule

// File: rtl/rtc_ram_top.sv
module rtc_ram_top
  import rtc_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  logic        cs,
  input  logic        we,
  input  logic        re,
  input  logic [10:0] addr,
  input  logic [7:0]  wdata,
  output logic [7:0]  rdata,
  output logic        rd_valid
);
  localparam int MEM_WORDS = 2 ** ADDR_W;
  localparam int RAM_DEPTH = MEM_WORDS - NUM_REGS;
  localparam logic [ADDR_W-1:0] REG_BASE = ADDR_W'(RAM_DEPTH);

  logic                       wr, rd, is_reg, ctrl_wr, load, refresh;
  logic                       w_bit, r_bit, rel_q;
  logic [2:0]                 reg_idx;
  logic [NUM_REGS*BYTE_W-1:0] hold_flat;
  rtc_time_t                  cnt_cur, cnt_nxt, load_val;
  logic [7:0]                 ram_q, reg_q;
  logic                       sel_reg_q;
  logic [2:0]                 rd_idx_q;

  assign wr      = cs && we;
  assign rd      = cs && re;
  assign is_reg  = (addr >= REG_BASE);
  assign reg_idx = addr[2:0];
  assign w_bit   = hold_flat[7];
  assign r_bit   = hold_flat[6];
  assign ctrl_wr = wr && is_reg && (reg_idx == 3'd0);
  assign load    = ctrl_wr && w_bit && !wdata[7];
  assign refresh = !w_bit && !r_bit && (tick || rel_q);

  // Load image: time bytes from the holding copy, century from the clearing write.
  always_comb begin
    load_val.cent = wdata[5:0];
    load_val.sec  = hold_flat[14:8];
    load_val.min  = hold_flat[22:16];
    load_val.hour = hold_flat[29:24];
    load_val.dow  = hold_flat[34:32];
    load_val.date = hold_flat[45:40];
    load_val.mon  = hold_flat[52:48];
    load_val.year = hold_flat[63:56];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rel_q <= 1'b0;
    else        rel_q <= ctrl_wr && ((w_bit && !wdata[7]) || (r_bit && !wdata[6]));
  end

  rtc_counters u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .load     (load),
    .load_val (load_val),
    .cur      (cnt_cur),
    .nxt      (cnt_nxt)
  );

  rtc_holding u_hold (
    .clk         (clk),
    .rst_n       (rst_n),
    .refresh     (refresh),
    .refresh_val (cnt_nxt),
    .wr_en       (wr && is_reg),
    .wr_idx      (reg_idx),
    .wdata       (wdata),
    .hold_flat   (hold_flat)
  );

  rtc_ram #(.ADDR_W(ADDR_W), .DEPTH(RAM_DEPTH), .DATA_W(BYTE_W)) u_ram (
    .clk   (clk),
    .we    (wr && !is_reg),
    .re    (rd && !is_reg),
    .addr  (addr),
    .wdata (wdata),
    .q     (ram_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid  <= 1'b0;
      sel_reg_q <= 1'b0;
      reg_q     <= '0;
      rd_idx_q  <= '0;
    end else begin
      rd_valid <= rd;
      if (rd) begin
        sel_reg_q <= is_reg;
        rd_idx_q  <= reg_idx;
        reg_q     <= hold_flat[{reg_idx, 3'b000} +: BYTE_W];
      end
    end
  end

  assign rdata = sel_reg_q ? reg_q : ram_q;

  p_rd_valid_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rd |=> rd_valid);
  p_rd_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> !rd_valid);
  p_sec_msb_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && sel_reg_q && rd_idx_q == 3'd1) |-> (rdata[7] == 1'b0));
  p_refresh_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !w_bit && !r_bit && !(wr && is_reg)) |=> (hold_flat[14:8] == cnt_cur.sec));
  p_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((w_bit || r_bit) && !(wr && is_reg)) |=> $stable(hold_flat[63:8]));
endmodule

// File: tb/tb_rtc_ram_top.sv
module tb_rtc_ram_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0, cs = 1'b0, we = 1'b0, re = 1'b0;
  logic [10:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        rd_valid;

  int    n_cmp = 0, n_bad = 0;
  string phase = "R2";

  always #10 clk = ~clk;

  rtc_ram_top dut (.*);

  // ---------------- behavioural reference model ----------------
  logic [7:0] mram [0:2039];
  logic [7:0] hold [0:7];
  int sec, mnt, hr, dow, dte, mon, yr, cen;
  bit m_rel, m_v;
  logic [7:0] m_d;

  function automatic logic [7:0] tobcd(input int v);
    return 8'((v / 10) * 16 + (v % 10));
  endfunction
  function automatic int frombcd(input logic [7:0] b);
    return int'(b[7:4]) * 10 + int'(b[3:0]);
  endfunction
  function automatic logic [7:0] msk(input int i);
    case (i)
      1, 2: return 8'h7F;
      3, 5: return 8'h3F;
      4: return 8'h07;
      6: return 8'h1F;
      default: return 8'hFF;
    endcase
  endfunction
  function automatic int mdays(input int m, input int y);
    if (m == 2) return (y % 4 == 0) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  task automatic m_advance();
    sec++;
    if (sec == 60) begin sec = 0; mnt++; end
    if (mnt == 60) begin mnt = 0; hr++; end
    if (hr == 24) begin
      hr = 0;
      dow = (dow == 7) ? 1 : dow + 1;
      dte++;
      if (dte > mdays(mon, yr)) begin dte = 1; mon++; end
      if (mon == 13) begin mon = 1; yr++; end
      if (yr == 100) begin yr = 0; cen++; end
      if (cen == 40) cen = 0;
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec = 0; mnt = 0; hr = 0; dow = 1; dte = 1; mon = 1; yr = 0; cen = 0;
      for (int i = 0; i < 8; i++) hold[i] = (i >= 4 && i <= 6) ? 8'h01 : 8'h00;
      m_rel = 0; m_v = 0; m_d = 0;
    end else begin
      bit mwr, mrd, isr, ctl, wb, rb, ld;
      int a, idx;
      mwr = cs && we; mrd = cs && re;
      a = int'(addr); isr = (a >= 2040); idx = a - 2040;
      m_v = mrd;
      if (mrd) m_d = isr ? hold[idx] : mram[a];
      wb = hold[0][7]; rb = hold[0][6];
      ctl = mwr && isr && idx == 0;
      ld = ctl && wb && !wdata[7];
      if (ld) begin
        sec = frombcd(hold[1]); mnt = frombcd(hold[2]); hr = frombcd(hold[3]);
        dow = int'(hold[4]); dte = frombcd(hold[5]); mon = frombcd(hold[6]);
        yr = frombcd(hold[7]); cen = frombcd(wdata & 8'h3F);
      end else if (tick) m_advance();
      if (!wb && !rb && (tick || m_rel)) begin
        hold[0] = {hold[0][7:6], 6'(tobcd(cen))};
        hold[1] = tobcd(sec); hold[2] = tobcd(mnt); hold[3] = tobcd(hr);
        hold[4] = 8'(dow); hold[5] = tobcd(dte); hold[6] = tobcd(mon); hold[7] = tobcd(yr);
      end
      m_rel = ctl && ((wb && !wdata[7]) || (rb && !wdata[6]));
      if (mwr) begin
        if (isr) hold[idx] = wdata & msk(idx);
        else mram[a] = wdata;
      end
    end
  end

  // ---------------- compare every clock, away from the active edge ----------------
  always @(negedge clk) begin
    if (rst_n) begin
      n_cmp++;
      if (rd_valid !== m_v) begin
        n_bad++;
        $display("FAIL %s rd_valid got %b expected %b", phase, rd_valid, m_v);
      end else if (m_v && rdata !== m_d) begin
        n_bad++;
        $display("FAIL %s rdata got %02h expected %02h", phase, rdata, m_d);
      end
    end
  end

  // ---------------- stimulus ----------------
  task automatic op(input bit w, input bit r, input bit t, input int a, input int d);
    @(negedge clk);
    cs = w | r; we = w; re = r; tick = t; addr = 11'(a); wdata = 8'(d);
  endtask
  task automatic wr(input int a, input int d); op(1, 0, 0, a, d); endtask
  task automatic rd(input int a); op(0, 1, 0, a, 0); endtask
  task automatic tk(); op(0, 0, 1, 0, 0); endtask
  task automatic quiet(); op(0, 0, 0, 0, 0); endtask
  task automatic rd_all();
    for (int i = 0; i < 8; i++) rd(2040 + i);
    quiet();
  endtask
  // Values given in BCD; a set-bit sequence ending in a load.
  task automatic set_time(input int c, input int y, input int mo, input int dt,
                          input int dw, input int h, input int mi, input int s);
    wr(2040, 8'h80 | c);
    wr(2041, s); wr(2042, mi); wr(2043, h); wr(2044, dw);
    wr(2045, dt); wr(2046, mo); wr(2047, y);
    wr(2040, c);
    quiet();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R2: reset contents of every clock byte
    phase = "R2"; rd_all();
    // R1: plain storage, including the highest RAM address and read-before-write
    phase = "R1";
    wr(0, 8'hAA); wr(11'h123, 8'h55); wr(11'h7F7, 8'hC3);
    rd(0); rd(11'h123); rd(11'h7F7);
    op(1, 1, 0, 11'h123, 8'h77); rd(11'h123); quiet();
    // R2: unused bits read as zero (written with all ones under the set bit)
    phase = "R2";
    wr(2040, 8'h80);
    for (int i = 1; i < 8; i++) wr(2040 + i, 8'hFF);
    rd_all();
    // R9: load a time and read it back, then continue counting from it
    phase = "R9";
    set_time(8'h20, 8'h24, 8'h01, 8'h15, 3, 8'h10, 8'h59, 8'h58);
    rd_all();
    // R3 and R7: second, minute and hour carries, visible right after each tick
    phase = "R3"; tk(); rd_all(); tk(); rd_all();
    phase = "R7"; tk(); rd(2041); tk(); tk(); rd(2041); quiet();
    // R4: day of week 7 -> 1 and 30-day month end
    phase = "R4";
    set_time(8'h20, 8'h23, 8'h04, 8'h30, 7, 8'h23, 8'h59, 8'h59); tk(); rd_all();
    set_time(8'h20, 8'h23, 8'h01, 8'h31, 2, 8'h23, 8'h59, 8'h59); tk(); rd_all();
    // R5: leap and non-leap February ends
    phase = "R5";
    set_time(8'h20, 8'h24, 8'h02, 8'h28, 3, 8'h23, 8'h59, 8'h59); tk(); rd_all();
    set_time(8'h20, 8'h24, 8'h02, 8'h29, 4, 8'h23, 8'h59, 8'h59); tk(); rd_all();
    set_time(8'h20, 8'h23, 8'h02, 8'h28, 2, 8'h23, 8'h59, 8'h59); tk(); rd_all();
    set_time(8'h20, 8'h00, 8'h02, 8'h28, 1, 8'h23, 8'h59, 8'h59); tk(); rd_all();
    // R6: year and century carries
    phase = "R6";
    set_time(8'h19, 8'h99, 8'h12, 8'h31, 5, 8'h23, 8'h59, 8'h59); tk(); rd_all();
    set_time(8'h39, 8'h99, 8'h12, 8'h31, 6, 8'h23, 8'h59, 8'h59); tk(); rd_all();
    // R8: freeze, keep ticking, release and see the elapsed time
    phase = "R8";
    wr(2040, 8'h40); tk(); tk(); tk(); rd(2041); rd(2040); quiet();
    wr(2040, 8'h00); quiet(); rd_all();
    // R9: ticks while the set bit is set do not reach the holding copy
    phase = "R9";
    wr(2040, 8'h80); tk(); tk(); rd(2041); wr(2041, 8'h45); rd(2041);
    wr(2040, 8'h00); tk(); rd_all();
    // R10: write with set bit clear is temporary
    phase = "R10";
    wr(2041, 8'h33); rd(2041); tk(); rd(2041); wr(2045, 8'h11); rd(2045); tk(); rd(2045); quiet();
    // R1: storage untouched by clock activity
    phase = "R1"; rd(0); rd(11'h7F7); quiet(); quiet();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not complete, got timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule